// File: doc/BRIEF.md
# Amplifier Mode and Protection Sequencer

This block is the digital sequencer of a two-channel switching audio amplifier. It takes an active-low reset pin, an active-low mute pin and one free-running clock. It also takes four comparator flags from the analog side: overcurrent, die temperature above the warning threshold, die temperature above the shutdown threshold, and die temperature back below the restore threshold. From these it drives a modulator enable for each channel, a power-stage switching enable and a tri-state control for the output bridge. It also drives three active-low error outputs.

After reset is released, the block counts out a fixed initialisation window. It then starts the modulators but keeps the bridge quiet until mute is released. Unmute and mute each take effect after their own fixed delay, and the two delays differ. An overcurrent event mutes the bridge at once and stays latched until the mute pin is pulsed or the block is reset. A thermal shutdown also mutes the bridge at once, but it clears by itself when the die cools: the restore flag must be high and neither temperature flag may be set. All five asynchronous inputs pass through two-flop synchronisers before any logic uses them.

Top module: `amp_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, every bit of `mod_en` is 0, `pwr_en` is 0, `out_hiz` is 1, and all three error outputs are 1 (inactive).
- R2: After `rst_n` rises, `mod_en` stays all-zero for INIT_CYC clock edges and becomes all-ones on edge INIT_CYC. A mute release during this window has no effect until the window ends.
- R3: When `mute_n` rises with no fault present, `pwr_en` goes to 1 and `out_hiz` to 0 exactly UNMUTE_DLY+3 edges later. The 3 edges are two synchroniser stages and one state update.
- R4: When `mute_n` falls while the bridge is switching, `pwr_en` stays 1 for MUTE_DLY+2 edges and drops to 0, with `out_hiz` at 1, on edge MUTE_DLY+3. `mod_en` stays all-ones.
- R5: If mute is asserted again during the unmute delay, switching never starts. A later release restarts the full unmute delay.
- R6: When `oc_flag` is set, `err_oc_n` goes low on the 3rd edge and `pwr_en` goes low on the 4th edge.
- R7: The overcurrent error and the forced mute persist after `oc_flag` clears, and they also persist while mute is merely held low.
- R8: A rise of `mute_n` (after a low period) clears the overcurrent error 3 edges later. Switching then starts UNMUTE_DLY+4 edges after the rise.
- R9: `warn_flag` drives `err_warn_n` low after 3 edges without stopping switching. The warning stays latched after `warn_flag` drops, until the restore condition.
- R10: `shut_flag` drives `err_shut_n` and `err_warn_n` low after 3 edges and `pwr_en` low after 4 edges. It stays that way until the restore condition, even after both temperature flags drop.
- R11: The restore condition is `restore_flag` high with `warn_flag` and `shut_flag` low. On it, both thermal errors return high on the same edge, 3 edges after it arises. If mute is released, switching resumes UNMUTE_DLY+4 edges after the condition arises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low reset; asynchronous clear of all state |
| mute_n | input | 1 | Active-low mute request (asynchronous) |
| oc_flag | input | 1 | Overcurrent comparator flag (asynchronous) |
| warn_flag | input | 1 | Die temperature above warning threshold |
| shut_flag | input | 1 | Die temperature above shutdown threshold |
| restore_flag | input | 1 | Die temperature below restore threshold |
| mod_en | output | NUM_CH | Per-channel modulator run enable |
| pwr_en | output | 1 | Output bridge switching enable |
| out_hiz | output | 1 | Output bridge tri-state control |
| err_shut_n | output | 1 | Thermal shutdown error, active low |
| err_warn_n | output | 1 | Thermal warning error, active low |
| err_oc_n | output | 1 | Overcurrent error, active low |

## Verification
The bench samples the exact edge on which switching starts and stops after each mute change. A counter that is off by one, or a missing synchroniser stage, shows up as a one-cycle shift in either direction. It re-asserts mute in the middle of the unmute delay, so a design that lets a running delay finish would start switching while muted. It holds mute low without releasing it while an overcurrent is latched, which catches a latch that clears on the level of mute instead of on its release. It also watches both thermal errors on every cycle of the restore, so a design that frees the warning and the shutdown errors on different edges is reported.

// File: rtl/amp_seq_pkg.sv
package amp_seq_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_MUTED = 3'd1,
    ST_RAMP  = 3'd2,
    ST_RUN   = 3'd3,
    ST_DRAIN = 3'd4
  } amp_state_e;

  function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold 0 .. lim-1.
  function automatic int unsigned count_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim);
  endfunction

  // True on the last cycle of a window of lim cycles.
  function automatic logic window_done(int unsigned elapsed, int unsigned lim);
    return (elapsed + 1) >= lim;
  endfunction

  function automatic logic is_switching(amp_state_e s);
    return (s == ST_RUN) || (s == ST_DRAIN);
  endfunction

endpackage

// File: rtl/amp_flag_sync.sv
module amp_flag_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= 2'b00;
      else        pipe <= {pipe[0], d[i]};
    end
    assign q[i] = pipe[1];
  end

endmodule

// File: rtl/amp_fault_tracker.sv
module amp_fault_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_s,
  input  logic warn_s,
  input  logic shut_s,
  input  logic restore_s,
  input  logic mute_s,
  output logic oc_lat,
  output logic warn_lat,
  output logic shut_lat,
  output logic mute_rise
);

  logic mute_d;
  logic cool;

  assign mute_rise = mute_s & ~mute_d;
  assign cool      = restore_s & ~warn_s & ~shut_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_d   <= 1'b0;
      oc_lat   <= 1'b0;
      warn_lat <= 1'b0;
      shut_lat <= 1'b0;
    end else begin
      mute_d <= mute_s;
      // overcurrent: set wins, cleared only by a mute release
      if (oc_s)           oc_lat <= 1'b1;
      else if (mute_rise) oc_lat <= 1'b0;
      // thermal: both errors released by the same cool condition
      if (warn_s | shut_s) warn_lat <= 1'b1;
      else if (cool)       warn_lat <= 1'b0;
      if (shut_s)          shut_lat <= 1'b1;
      else if (cool)       shut_lat <= 1'b0;
    end
  end

endmodule

// File: rtl/amp_mode_fsm.sv
module amp_mode_fsm
  import amp_seq_pkg::*;
#(
  parameter int unsigned INIT_CYC   = 1024,
  parameter int unsigned MUTE_DLY   = 123,
  parameter int unsigned UNMUTE_DLY = 418
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mute_s,
  input  logic halt,
  output logic switching,
  output logic mod_run
);

  localparam int unsigned LONGEST = max_of3(INIT_CYC, MUTE_DLY, UNMUTE_DLY);
  localparam int unsigned CW      = count_bits(LONGEST);

  amp_state_e      state_q, state_d;
  logic [CW-1:0]   cnt_q;
  logic            timed;
  int unsigned     elapsed;

  assign elapsed = int'(cnt_q);
  assign timed   = (state_q == ST_INIT) || (state_q == ST_RAMP) || (state_q == ST_DRAIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_INIT:  if (window_done(elapsed, INIT_CYC)) state_d = ST_MUTED;
      ST_MUTED: if (mute_s && !halt)                state_d = ST_RAMP;
      ST_RAMP: begin
        if (halt || !mute_s)                        state_d = ST_MUTED;
        else if (window_done(elapsed, UNMUTE_DLY))  state_d = ST_RUN;
      end
      ST_RUN: begin
        if (halt)                                   state_d = ST_MUTED;
        else if (!mute_s)                           state_d = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (halt)                                   state_d = ST_MUTED;
        else if (window_done(elapsed, MUTE_DLY))    state_d = ST_MUTED;
      end
      default:                                      state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_INIT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (timed)         cnt_q <= cnt_q + CW'(1);
    end
  end

  assign switching = is_switching(state_q);
  assign mod_run   = (state_q != ST_INIT);

endmodule

// File: rtl/amp_seq_ctrl.sv
module amp_seq_ctrl
  import amp_seq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned INIT_CYC   = 1024,
  parameter int unsigned MUTE_DLY   = 123,
  parameter int unsigned UNMUTE_DLY = 418
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_n,
  input  logic              oc_flag,
  input  logic              warn_flag,
  input  logic              shut_flag,
  input  logic              restore_flag,
  output logic [NUM_CH-1:0] mod_en,
  output logic              pwr_en,
  output logic              out_hiz,
  output logic              err_shut_n,
  output logic              err_warn_n,
  output logic              err_oc_n
);

  localparam int unsigned NSYNC = 5;

  logic [NSYNC-1:0] raw_in, synced;
  logic mute_s, oc_s, warn_s, shut_s, restore_s;
  logic oc_lat, warn_lat, shut_lat, mute_rise;
  logic halt, switching, mod_run;

  assign raw_in = {restore_flag, shut_flag, warn_flag, oc_flag, mute_n};

  amp_flag_sync #(.W(NSYNC)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (raw_in),
    .q   (synced)
  );

  assign mute_s    = synced[0];
  assign oc_s      = synced[1];
  assign warn_s    = synced[2];
  assign shut_s    = synced[3];
  assign restore_s = synced[4];

  amp_fault_tracker u_faults (
    .clk       (clk),
    .rst_n     (rst_n),
    .oc_s      (oc_s),
    .warn_s    (warn_s),
    .shut_s    (shut_s),
    .restore_s (restore_s),
    .mute_s    (mute_s),
    .oc_lat    (oc_lat),
    .warn_lat  (warn_lat),
    .shut_lat  (shut_lat),
    .mute_rise (mute_rise)
  );

  assign halt = oc_lat | shut_lat;

  amp_mode_fsm #(
    .INIT_CYC   (INIT_CYC),
    .MUTE_DLY   (MUTE_DLY),
    .UNMUTE_DLY (UNMUTE_DLY)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mute_s    (mute_s),
    .halt      (halt),
    .switching (switching),
    .mod_run   (mod_run)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign mod_en[c] = mod_run;
  end

  assign pwr_en     = switching;
  assign out_hiz    = ~switching;
  assign err_oc_n   = ~oc_lat;
  assign err_warn_n = ~warn_lat;
  assign err_shut_n = ~shut_lat;

endmodule

// File: rtl/amp_seq_chk.sv
module amp_seq_chk #(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned INIT_CYC   = 1024,
  parameter int unsigned MUTE_DLY   = 123,
  parameter int unsigned UNMUTE_DLY = 418
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mute_s,
  input logic              halt,
  input logic              mute_rise,
  input logic [NUM_CH-1:0] mod_en,
  input logic              pwr_en,
  input logic              out_hiz,
  input logic              err_shut_n,
  input logic              err_warn_n,
  input logic              err_oc_n
);

  logic [31:0] since_rst, hi_run, lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      hi_run    <= '0;
      lo_run    <= '0;
    end else begin
      if (since_rst != 32'hFFFF_FFFF) since_rst <= since_rst + 32'd1;
      if (mute_s && !halt) begin
        if (hi_run != 32'hFFFF_FFFF) hi_run <= hi_run + 32'd1;
      end else hi_run <= '0;
      if (!mute_s && pwr_en) lo_run <= lo_run + 32'd1;
      else                   lo_run <= '0;
    end
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (mod_en == '0 && !pwr_en && out_hiz && err_oc_n && err_warn_n && err_shut_n);
    end
  end

  // R2
  init_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en != '0) |-> (since_rst >= INIT_CYC));

  // R3
  unmute_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> (hi_run >= UNMUTE_DLY));

  // R4
  mute_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lo_run <= (MUTE_DLY + 1));

  // R6
  oc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_oc_n |=> !pwr_en);

  // R7
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_oc_n && !mute_rise) |=> !err_oc_n);

  // R10
  shut_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_shut_n |=> !pwr_en);

  // R10
  shut_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !err_shut_n |-> !err_warn_n);

  // R11
  thermal_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_shut_n) |-> $rose(err_warn_n));

endmodule

bind amp_seq_ctrl amp_seq_chk #(
  .NUM_CH     (NUM_CH),
  .INIT_CYC   (INIT_CYC),
  .MUTE_DLY   (MUTE_DLY),
  .UNMUTE_DLY (UNMUTE_DLY)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mute_s     (mute_s),
  .halt       (halt),
  .mute_rise  (mute_rise),
  .mod_en     (mod_en),
  .pwr_en     (pwr_en),
  .out_hiz    (out_hiz),
  .err_shut_n (err_shut_n),
  .err_warn_n (err_warn_n),
  .err_oc_n   (err_oc_n)
);

// File: tb/tb_amp_seq_ctrl.sv
module tb_amp_seq_ctrl;

  localparam int NUM_CH = 2;
  localparam int INIT   = 1024;
  localparam int MDLY   = 123;
  localparam int UDLY   = 418;

  logic clk = 1'b0;
  logic rst_n = 1'b0, mute_n = 1'b0, oc_flag = 1'b0;
  logic warn_flag = 1'b0, shut_flag = 1'b0, restore_flag = 1'b0;
  logic [NUM_CH-1:0] mod_en;
  logic pwr_en, out_hiz, err_shut_n, err_warn_n, err_oc_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  amp_seq_ctrl #(
    .NUM_CH(NUM_CH), .INIT_CYC(INIT), .MUTE_DLY(MDLY), .UNMUTE_DLY(UDLY)
  ) dut (
    .clk(clk), .rst_n(rst_n), .mute_n(mute_n), .oc_flag(oc_flag),
    .warn_flag(warn_flag), .shut_flag(shut_flag), .restore_flag(restore_flag),
    .mod_en(mod_en), .pwr_en(pwr_en), .out_hiz(out_hiz),
    .err_shut_n(err_shut_n), .err_warn_n(err_warn_n), .err_oc_n(err_oc_n)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait n rising edges, then settle at the falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    step(3);
    check("R1 mod_en", int'(mod_en), 0);
    check("R1 pwr_en", int'(pwr_en), 0);
    check("R1 out_hiz", int'(out_hiz), 1);
    check("R1 errors", int'({err_shut_n, err_warn_n, err_oc_n}), 7);
    mute_n = 1'b1;           // released while still in reset
    step(4);
    check("R1 pwr_en under released mute", int'(pwr_en), 0);
  endtask

  task automatic t_init();
    rst_n = 1'b1;
    step(INIT - 1);
    check("R2 mod_en before window end", int'(mod_en), 0);
    check("R2 pwr_en ignores early unmute", int'(pwr_en), 0);
    step(1);
    check("R2 mod_en at window end", int'(mod_en), 3);
    step(UDLY);
    check("R3 pwr_en one edge early", int'(pwr_en), 0);
    step(1);
    check("R3 pwr_en on time", int'(pwr_en), 1);
    check("R3 out_hiz on time", int'(out_hiz), 0);
  endtask

  task automatic t_mute();
    mute_n = 1'b0;
    step(MDLY + 2);
    check("R4 pwr_en still on", int'(pwr_en), 1);
    step(1);
    check("R4 pwr_en off", int'(pwr_en), 0);
    check("R4 out_hiz", int'(out_hiz), 1);
    check("R4 mod_en kept", int'(mod_en), 3);
  endtask

  task automatic t_unmute();
    mute_n = 1'b1;
    step(UDLY + 2);
    check("R3 pwr_en early", int'(pwr_en), 0);
    step(1);
    check("R3 pwr_en on", int'(pwr_en), 1);
  endtask

  task automatic t_abort();
    int seen_on;
    mute_n = 1'b0;
    step(MDLY + 10);
    mute_n = 1'b1;
    step(100);
    mute_n = 1'b0;
    seen_on = 0;
    for (int i = 0; i < UDLY + 50; i++) begin
      step(1);
      if (pwr_en) seen_on++;
    end
    check("R5 no switching after abort", seen_on, 0);
    mute_n = 1'b1;
    step(UDLY + 2);
    check("R5 restart full delay early", int'(pwr_en), 0);
    step(1);
    check("R5 restart full delay on", int'(pwr_en), 1);
  endtask

  task automatic t_oc();
    oc_flag = 1'b1;
    step(3);
    check("R6 err_oc_n", int'(err_oc_n), 0);
    check("R6 pwr_en before stop", int'(pwr_en), 1);
    step(1);
    check("R6 pwr_en stopped", int'(pwr_en), 0);
    oc_flag = 1'b0;
    step(UDLY + 20);
    check("R7 err_oc_n held", int'(err_oc_n), 0);
    check("R7 pwr_en held off", int'(pwr_en), 0);
  endtask

  task automatic t_oc_clear();
    mute_n = 1'b0;
    step(10);
    check("R7 err_oc_n while mute low", int'(err_oc_n), 0);
    mute_n = 1'b1;
    step(2);
    check("R8 err_oc_n before clear", int'(err_oc_n), 0);
    step(1);
    check("R8 err_oc_n cleared", int'(err_oc_n), 1);
    step(UDLY);
    check("R8 pwr_en early", int'(pwr_en), 0);
    step(1);
    check("R8 pwr_en resumed", int'(pwr_en), 1);
  endtask

  task automatic t_warn();
    warn_flag = 1'b1;
    step(3);
    check("R9 err_warn_n", int'(err_warn_n), 0);
    check("R9 err_shut_n", int'(err_shut_n), 1);
    step(50);
    check("R9 still switching", int'(pwr_en), 1);
    warn_flag = 1'b0;
    step(10);
    check("R9 warning latched", int'(err_warn_n), 0);
    restore_flag = 1'b1;
    step(3);
    check("R11 warning released", int'(err_warn_n), 1);
    restore_flag = 1'b0;
    step(2);
  endtask

  task automatic t_shutdown();
    int split;
    warn_flag = 1'b1;
    shut_flag = 1'b1;
    step(3);
    check("R10 err_shut_n", int'(err_shut_n), 0);
    check("R10 err_warn_n", int'(err_warn_n), 0);
    step(1);
    check("R10 pwr_en stopped", int'(pwr_en), 0);
    shut_flag = 1'b0;
    warn_flag = 1'b0;
    step(20);
    check("R10 held without restore", int'({err_shut_n, err_warn_n, pwr_en}), 0);
    restore_flag = 1'b1;
    split = 0;
    for (int i = 0; i < 6; i++) begin
      step(1);
      if (err_shut_n != err_warn_n) split++;
    end
    check("R11 errors cleared together", split, 0);
    check("R11 both cleared", int'({err_shut_n, err_warn_n}), 3);
    step(UDLY - 3);
    check("R11 pwr_en early", int'(pwr_en), 0);
    step(1);
    check("R11 pwr_en resumed", int'(pwr_en), 1);
    restore_flag = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_init();
    t_mute();
    t_unmute();
    t_abort();
    t_oc();
    t_oc_clear();
    t_warn();
    t_shutdown();
    step(5);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule